// File: doc/BRIEF.md
# Framed Synchronous Serial Port Slave

This block is the slave end of a framed, bit-serial link. An external master owns the bit clock and the frame sync. The block shifts a parallel word out on a serial data pin, most significant bit first, and assembles a word from the serial input pin in the same order. The first data bit of a frame follows the frame sync by one bit period. Three configuration inputs set the port's behaviour. The first chooses the active level of the frame sync. The second chooses which bit-clock edge launches outgoing data; incoming data is sampled on the other edge. The third selects between six-pin and four-pin wiring. In six-pin wiring each direction has its own clock and sync pins. In four-pin wiring the receive side reuses the transmit clock and sync, and the separate receive pins are ignored.

All serial pins are brought into the system clock domain through multi-stage synchronizers. Bit-clock edges are then found by comparing successive synchronized samples, so the parallel interfaces and every piece of state sit in one clock domain. Each level of the bit clock must therefore last at least three system clock cycles. A transmit word is offered through a valid/ready handshake into a one-word holding register, and each frame sync consumes that register. A received word appears with a one-cycle valid pulse. Single-cycle flags report a frame that had no new word to send and a frame sync that cut a word short.

Top module: `ssp_slave`

## Requirements
- R1: Transmit shifts exactly WORD_W bits per frame, most significant bit first, with one new bit on `ser_dout` for each launch edge of the transmit bit clock.
- R2: A frame sync is detected on a capture edge. The most significant bit is launched on the first launch edge after that detection, and the receiver samples its first bit on the next capture edge after that detection. Before that launch, `ser_dout_en` keeps its idle value.
- R3: With `cfg_fs_low` = 0 the frame sync is active high; with 1 it is active low. A frame starts when the sync is active at a capture edge and was inactive at the previous capture edge.
- R4: With `cfg_launch_fall` = 0 data is launched on the rising bit-clock edge and sampled on the falling edge; with 1 the edges swap.
- R5: With `cfg_four_pin` = 0 the receiver runs only from `rx_bclk`/`rx_fsync`, and transmit runs only from `tx_bclk`/`tx_fsync`.
- R6: With `cfg_four_pin` = 1 the receiver runs from `tx_bclk`/`tx_fsync`, and activity on `rx_bclk`/`rx_fsync` produces no received word.
- R7: Once the last bit of a frame has been sampled, `rx_data` holds the assembled word (first sampled bit in bit WORD_W-1) and `rx_valid` is high for exactly one cycle.
- R8: `tx_ready` is high while the holding register is empty. A word is accepted when `tx_valid` and `tx_ready` are both high, and a frame sync empties the register into the shifter.
- R9: A frame sync that finds the holding register empty resends the previously sent word (zero after reset) and pulses `tx_underrun` for one cycle. A handshake in that same cycle is kept for the next frame.
- R10: A frame sync that arrives while bits of the current word remain restarts that direction's shifter with a new word and pulses `tx_fs_err` or `rx_fs_err` for one cycle.
- R11: When no word is being shifted, `ser_dout` is 0. With IDLE_RELEASE = 1, `ser_dout_en` is 0 when idle and 1 while shifting; with IDLE_RELEASE = 0 it is always 1. Idle begins at the first launch edge after the last bit with no new frame.
- R12: After reset `tx_ready` is 1; `rx_valid`, the flags and `ser_dout` are 0; `ser_dout_en` is at its idle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_four_pin | input | 1 | 1: receive side uses the transmit clock and sync |
| cfg_fs_low | input | 1 | 1: frame sync active low |
| cfg_launch_fall | input | 1 | 1: launch on falling edge, sample on rising |
| tx_bclk | input | 1 | Transmit bit clock from master |
| tx_fsync | input | 1 | Transmit frame sync from master |
| rx_bclk | input | 1 | Receive bit clock from master (six-pin only) |
| rx_fsync | input | 1 | Receive frame sync from master (six-pin only) |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out |
| ser_dout_en | output | 1 | Output enable for the data-out pad |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle pulse for a new received word |
| tx_underrun | output | 1 | Frame started with no new word |
| tx_fs_err | output | 1 | Transmit frame sync cut a word short |
| rx_fs_err | output | 1 | Receive frame sync cut a word short |

## Verification
A frame sync detection and a transmit handshake can land in the same system cycle. One empties the holding register and the other fills it. The bench provokes this by raising `tx_valid` for the single cycle in which the synchronized capture edge that carries the sync takes effect, two cycles after the pin change. It judges the result by four things: an underrun pulse, the previous word appearing on the line, `tx_ready` low after the frame, and the new word carried by the following frame with no further underrun.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

   // Per-direction events decoded from the synchronized bit clock and sync.
   typedef struct packed {
      logic launch;    // edge on which outgoing data changes
      logic capture;   // edge on which incoming data is sampled
      logic fs_start;  // capture edge that opens a frame
   } ssp_evt_t;

   localparam int unsigned SSP_PIN_COUNT = 5;

endpackage

// File: rtl/ssp_pin_sync.sv
module ssp_pin_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_raw,
   output logic [WIDTH-1:0] pin_sync
);

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= pin_raw;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/ssp_edge_gen.sv
module ssp_edge_gen
   import ssp_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     bclk_s,
   input  logic     fs_s,
   input  logic     cfg_launch_fall,
   input  logic     cfg_fs_low,
   output ssp_evt_t evt
);

   logic bclk_d;
   logic fs_seen_q;
   logic rise, fall, fs_act;

   assign rise   = bclk_s & ~bclk_d;
   assign fall   = ~bclk_s & bclk_d;
   assign fs_act = fs_s ^ cfg_fs_low;

   assign evt.launch   = cfg_launch_fall ? fall : rise;
   assign evt.capture  = cfg_launch_fall ? rise : fall;
   assign evt.fs_start = evt.capture & fs_act & ~fs_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_d    <= 1'b0;
         fs_seen_q <= 1'b0;
      end else begin
         bclk_d <= bclk_s;
         if (evt.capture) fs_seen_q <= fs_act;
      end
   end

endmodule

// File: rtl/ssp_tx_path.sv
module ssp_tx_path
   import ssp_pkg::*;
#(
   parameter int unsigned WORD_W       = 8,
   parameter bit          IDLE_RELEASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ssp_evt_t          evt,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              ser_dout,
   output logic              ser_dout_en,
   output logic              underrun,
   output logic              fs_err
);

   localparam int unsigned CNT_W = $clog2(WORD_W + 1);

   logic [WORD_W-1:0] hold_q, last_q, shift_q;
   logic              hold_full_q;
   logic [CNT_W-1:0]  left_q;
   logic              active_q, bit_q;
   logic              underrun_q, fs_err_q;

   assign tx_ready = ~hold_full_q;
   assign underrun = underrun_q;
   assign fs_err   = fs_err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         last_q      <= '0;
         shift_q     <= '0;
         hold_full_q <= 1'b0;
         left_q      <= '0;
         active_q    <= 1'b0;
         bit_q       <= 1'b0;
         underrun_q  <= 1'b0;
         fs_err_q    <= 1'b0;
      end else begin
         underrun_q <= 1'b0;
         fs_err_q   <= 1'b0;
         if (evt.fs_start) begin
            fs_err_q <= (left_q != '0);
            left_q   <= CNT_W'(WORD_W);
            if (hold_full_q) begin
               shift_q     <= hold_q;
               last_q      <= hold_q;
               hold_full_q <= 1'b0;
            end else begin
               shift_q    <= last_q;
               underrun_q <= 1'b1;
            end
         end else if (evt.launch) begin
            if (left_q != '0) begin
               bit_q    <= shift_q[WORD_W-1];
               shift_q  <= {shift_q[WORD_W-2:0], 1'b0};
               left_q   <= left_q - CNT_W'(1);
               active_q <= 1'b1;
            end else begin
               bit_q    <= 1'b0;
               active_q <= 1'b0;
            end
         end
         // Holding register accepts only while empty; cannot clash with
         // the consume above, which needs it full.
         if (tx_valid && !hold_full_q) begin
            hold_q      <= tx_data;
            hold_full_q <= 1'b1;
         end
      end
   end

   assign ser_dout = bit_q;

   if (IDLE_RELEASE) begin : g_release
      assign ser_dout_en = active_q;
   end else begin : g_drive_zero
      assign ser_dout_en = 1'b1;
   end

endmodule

// File: rtl/ssp_rx_path.sv
module ssp_rx_path
   import ssp_pkg::*;
#(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ssp_evt_t          evt,
   input  logic              din_s,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              fs_err
);

   localparam int unsigned CNT_W = $clog2(WORD_W + 1);

   logic [WORD_W-1:0] shift_q, data_q;
   logic [CNT_W-1:0]  left_q;
   logic              valid_q, fs_err_q;
   logic [WORD_W-1:0] next_word;

   assign next_word = {shift_q[WORD_W-2:0], din_s};
   assign rx_data   = data_q;
   assign rx_valid  = valid_q;
   assign fs_err    = fs_err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q  <= '0;
         data_q   <= '0;
         left_q   <= '0;
         valid_q  <= 1'b0;
         fs_err_q <= 1'b0;
      end else begin
         valid_q  <= 1'b0;
         fs_err_q <= 1'b0;
         if (evt.fs_start) begin
            fs_err_q <= (left_q != '0);
            left_q   <= CNT_W'(WORD_W);
         end else if (evt.capture && left_q != '0) begin
            shift_q <= next_word;
            left_q  <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
               data_q  <= next_word;
               valid_q <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ssp_slave.sv
module ssp_slave
   import ssp_pkg::*;
#(
   parameter int unsigned WORD_W       = 8,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          IDLE_RELEASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_four_pin,
   input  logic              cfg_fs_low,
   input  logic              cfg_launch_fall,
   input  logic              tx_bclk,
   input  logic              tx_fsync,
   input  logic              rx_bclk,
   input  logic              rx_fsync,
   input  logic              ser_din,
   output logic              ser_dout,
   output logic              ser_dout_en,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              tx_underrun,
   output logic              tx_fs_err,
   output logic              rx_fs_err
);

   localparam int unsigned SIDES = 2;

   if (WORD_W < 2) begin : g_bad_word
      $error("ssp_slave: WORD_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ssp_slave: SYNC_STAGES must be at least 2");
   end

   logic [SSP_PIN_COUNT-1:0] pins_raw, pins_s;
   logic [SIDES-1:0]         bclk_pick, fs_pick;
   ssp_evt_t                 evt [SIDES];

   assign pins_raw = {ser_din, rx_fsync, rx_bclk, tx_fsync, tx_bclk};

   ssp_pin_sync #(
      .WIDTH  (SSP_PIN_COUNT),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_raw  (pins_raw),
      .pin_sync (pins_s)
   );

   // side 0 = transmit, side 1 = receive (looped to transmit pins in 4-pin)
   assign bclk_pick[0] = pins_s[0];
   assign fs_pick[0]   = pins_s[1];
   assign bclk_pick[1] = cfg_four_pin ? pins_s[0] : pins_s[2];
   assign fs_pick[1]   = cfg_four_pin ? pins_s[1] : pins_s[3];

   for (genvar g = 0; g < SIDES; g++) begin : g_side
      ssp_edge_gen u_edge (
         .clk             (clk),
         .rst_n           (rst_n),
         .bclk_s          (bclk_pick[g]),
         .fs_s            (fs_pick[g]),
         .cfg_launch_fall (cfg_launch_fall),
         .cfg_fs_low      (cfg_fs_low),
         .evt             (evt[g])
      );
   end

   ssp_tx_path #(
      .WORD_W       (WORD_W),
      .IDLE_RELEASE (IDLE_RELEASE)
   ) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt         (evt[0]),
      .tx_data     (tx_data),
      .tx_valid    (tx_valid),
      .tx_ready    (tx_ready),
      .ser_dout    (ser_dout),
      .ser_dout_en (ser_dout_en),
      .underrun    (tx_underrun),
      .fs_err      (tx_fs_err)
   );

   ssp_rx_path #(
      .WORD_W (WORD_W)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt[1]),
      .din_s    (pins_s[4]),
      .rx_data  (rx_data),
      .rx_valid (rx_valid),
      .fs_err   (rx_fs_err)
   );

endmodule

// File: rtl/ssp_slave_chk.sv
module ssp_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_valid,
   input logic tx_ready,
   input logic rx_valid,
   input logic tx_underrun,
   input logic tx_fs_err,
   input logic rx_fs_err,
   input logic ser_dout,
   input logic ser_dout_en
);

   assert_rx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_accept_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);

   assert_underrun_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun |-> $past(tx_ready));

   assert_underrun_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun |=> !tx_underrun);

   assert_tx_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fs_err |=> !tx_fs_err);

   assert_rx_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fs_err |=> !rx_fs_err);

   assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_dout_en |-> !ser_dout);

endmodule

bind ssp_slave ssp_slave_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_valid    (tx_valid),
   .tx_ready    (tx_ready),
   .rx_valid    (rx_valid),
   .tx_underrun (tx_underrun),
   .tx_fs_err   (tx_fs_err),
   .rx_fs_err   (rx_fs_err),
   .ser_dout    (ser_dout),
   .ser_dout_en (ser_dout_en)
);

// File: tb/test_ssp_slave.sv
`timescale 1ns/1ps
module test_ssp_slave;

   localparam int W    = 8;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_four_pin = 1'b0, cfg_fs_low = 1'b0, cfg_launch_fall = 1'b0;
   logic tx_bclk = 1'b0, tx_fsync = 1'b0, rx_bclk = 1'b0, rx_fsync = 1'b0;
   logic ser_din = 1'b0;
   logic ser_dout, ser_dout_en, tx_ready, rx_valid;
   logic tx_underrun, tx_fs_err, rx_fs_err;
   logic [W-1:0] tx_data = '0, rx_data;
   logic tx_valid = 1'b0;
   logic z_dout, z_en, z_ready, z_rvalid, z_ur, z_te, z_re;
   logic [W-1:0] z_rdata;

   int vectors = 0, fails = 0;
   int rx_cnt = 0, ur_cnt = 0, txe_cnt = 0, rxe_cnt = 0;
   logic [W-1:0] rx_last = '0;
   bit timed_out = 0;

   always #2 clk = ~clk;

   ssp_slave #(.WORD_W(W)) i_ssp_slave (
      .clk(clk), .rst_n(rst_n), .cfg_four_pin(cfg_four_pin), .cfg_fs_low(cfg_fs_low),
      .cfg_launch_fall(cfg_launch_fall), .tx_bclk(tx_bclk), .tx_fsync(tx_fsync),
      .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .ser_din(ser_din), .ser_dout(ser_dout),
      .ser_dout_en(ser_dout_en), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
      .tx_underrun(tx_underrun), .tx_fs_err(tx_fs_err), .rx_fs_err(rx_fs_err));

   // drive-zero variant on the same pins, only its idle output is judged
   ssp_slave #(.WORD_W(W), .IDLE_RELEASE(1'b0)) i_ssp_slave_zero (
      .clk(clk), .rst_n(rst_n), .cfg_four_pin(cfg_four_pin), .cfg_fs_low(cfg_fs_low),
      .cfg_launch_fall(cfg_launch_fall), .tx_bclk(tx_bclk), .tx_fsync(tx_fsync),
      .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .ser_din(ser_din), .ser_dout(z_dout),
      .ser_dout_en(z_en), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(z_ready), .rx_data(z_rdata), .rx_valid(z_rvalid),
      .tx_underrun(z_ur), .tx_fs_err(z_te), .rx_fs_err(z_re));

   always @(negedge clk) begin
      if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
      if (tx_underrun) ur_cnt++;
      if (tx_fs_err) txe_cnt++;
      if (rx_fs_err) rxe_cnt++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_word(input logic [W-1:0] w);
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b1; tx_data = w;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic edge_to(input logic lvl, input bit dtx, input bit drx);
      if (dtx) tx_bclk = lvl;
      if (drx) rx_bclk = lvl;
   endtask

   task automatic sync_to(input logic act, input bit dtx, input bit drx);
      logic lvl;
      lvl = act ^ cfg_fs_low;
      if (dtx) tx_fsync = lvl;
      if (drx) rx_fsync = lvl;
   endtask

   // Master frame: period 0 carries the sync, then nbits data periods.
   task automatic run_frame(input logic [W-1:0] dword, input int nbits,
                            input bit idle_after, input bit dtx, input bit drx,
                            input bit collide, input logic [W-1:0] cword,
                            output logic [W-1:0] got, output logic en_early);
      logic launch_lvl;
      launch_lvl = ~cfg_launch_fall;
      got = '0;
      edge_to(launch_lvl, dtx, drx); sync_to(1'b1, dtx, drx);
      wait_n(HALF);
      en_early = ser_dout_en;
      edge_to(~launch_lvl, dtx, drx);
      if (collide) begin
         wait_n(2);
         tx_valid = 1'b1; tx_data = cword;
         wait_n(1);
         tx_valid = 1'b0;
         wait_n(1);
      end else wait_n(HALF);
      for (int i = 0; i < nbits; i++) begin
         edge_to(launch_lvl, dtx, drx); sync_to(1'b0, dtx, drx);
         ser_din = dword[W-1-i];
         wait_n(HALF);
         got[W-1-i] = ser_dout;
         edge_to(~launch_lvl, dtx, drx);
         wait_n(HALF);
      end
      if (idle_after) begin
         edge_to(launch_lvl, dtx, drx); sync_to(1'b0, dtx, drx);
         ser_din = 1'b0;
         wait_n(HALF);
         edge_to(~launch_lvl, dtx, drx);
         wait_n(2 * HALF);
      end
   endtask

   task automatic t_reset;
      chk(tx_ready == 1'b1, "R12", "tx_ready", tx_ready, 1);
      chk(rx_valid == 1'b0 && tx_underrun == 1'b0 && tx_fs_err == 1'b0 && rx_fs_err == 1'b0,
          "R12", "flags", {rx_valid, tx_underrun, tx_fs_err, rx_fs_err}, 0);
      chk(ser_dout == 1'b0 && ser_dout_en == 1'b0, "R12", "dout/en", {ser_dout, ser_dout_en}, 0);
      chk(z_en == 1'b1 && z_dout == 1'b0, "R12", "zero variant dout/en", {z_dout, z_en}, 1);
   endtask

   task automatic t_basic;
      logic [W-1:0] got; logic early; int r0, u0;
      r0 = rx_cnt; u0 = ur_cnt;
      load_word(8'hA5);
      run_frame(8'h3C, W, 1, 1, 1, 0, '0, got, early);
      chk(got == 8'hA5, "R1", "msb-first tx word", got, 8'hA5);
      chk(early == 1'b0, "R2", "enable before first launch", early, 0);
      chk(rx_cnt == r0 + 1 && rx_last == 8'h3C, "R7", "rx word", rx_last, 8'h3C);
      chk(tx_ready == 1'b1 && ur_cnt == u0, "R8", "holding consumed, no underrun", {tx_ready, 8'(ur_cnt - u0)}, 9'h100);
      chk(ser_dout_en == 1'b0 && ser_dout == 1'b0, "R11", "release variant idle", {ser_dout, ser_dout_en}, 0);
      chk(z_en == 1'b1 && z_dout == 1'b0, "R11", "drive-zero variant idle", {z_dout, z_en}, 1);
   endtask

   task automatic t_polarity;
      logic [W-1:0] got; logic early;
      cfg_fs_low = 1'b1; tx_fsync = 1'b1; rx_fsync = 1'b1;
      wait_n(8);
      load_word(8'h96);
      run_frame(8'h69, W, 1, 1, 1, 0, '0, got, early);
      chk(got == 8'h96, "R3", "active-low sync tx", got, 8'h96);
      chk(rx_last == 8'h69, "R3", "active-low sync rx", rx_last, 8'h69);
      cfg_fs_low = 1'b0; tx_fsync = 1'b0; rx_fsync = 1'b0;
      wait_n(8);
   endtask

   task automatic t_edge;
      logic [W-1:0] got; logic early;
      cfg_launch_fall = 1'b1; tx_bclk = 1'b1; rx_bclk = 1'b1;
      wait_n(8);
      load_word(8'hC1);
      run_frame(8'h1E, W, 1, 1, 1, 0, '0, got, early);
      chk(got == 8'hC1, "R4", "falling launch tx", got, 8'hC1);
      chk(rx_last == 8'h1E, "R4", "rising sample rx", rx_last, 8'h1E);
      cfg_launch_fall = 1'b0; tx_bclk = 1'b0; rx_bclk = 1'b0;
      wait_n(8);
   endtask

   task automatic t_six_pin;
      logic [W-1:0] got; logic early; int r0, u0;
      r0 = rx_cnt; u0 = ur_cnt;
      run_frame(8'h5B, W, 1, 0, 1, 0, '0, got, early);
      chk(rx_cnt == r0 + 1 && rx_last == 8'h5B, "R5", "rx from own pins", rx_last, 8'h5B);
      chk(got == '0 && ur_cnt == u0, "R5", "tx untouched by rx pins", {got, 8'(ur_cnt - u0)}, 0);
   endtask

   task automatic t_four_pin;
      logic [W-1:0] got; logic early; int r0;
      cfg_four_pin = 1'b1;
      wait_n(8);
      r0 = rx_cnt;
      run_frame(8'hFF, W, 1, 0, 1, 0, '0, got, early);
      chk(rx_cnt == r0, "R6", "rx pins ignored", rx_cnt - r0, 0);
      load_word(8'h3A);
      run_frame(8'hA3, W, 1, 1, 0, 0, '0, got, early);
      chk(got == 8'h3A, "R6", "tx in four-pin", got, 8'h3A);
      chk(rx_cnt == r0 + 1 && rx_last == 8'hA3, "R6", "rx looped from tx pins", rx_last, 8'hA3);
      cfg_four_pin = 1'b0;
      wait_n(8);
   endtask

   task automatic t_underrun;
      logic [W-1:0] got; logic early; int u0;
      u0 = ur_cnt;
      run_frame(8'h00, W, 1, 1, 1, 0, '0, got, early);
      chk(got == 8'h3A, "R9", "resend previous word", got, 8'h3A);
      chk(ur_cnt == u0 + 1, "R9", "underrun pulses", ur_cnt - u0, 1);
   endtask

   task automatic t_collide;
      logic [W-1:0] got; logic early; int u0;
      u0 = ur_cnt;
      run_frame(8'h11, W, 1, 1, 1, 1, 8'hE7, got, early);
      chk(got == 8'h3A && ur_cnt == u0 + 1, "R9", "collision: old word + underrun",
          {got, 8'(ur_cnt - u0)}, {8'h3A, 8'h01});
      chk(tx_ready == 1'b0, "R8", "collision word held", tx_ready, 0);
      u0 = ur_cnt;
      run_frame(8'h22, W, 1, 1, 1, 0, '0, got, early);
      chk(got == 8'hE7 && ur_cnt == u0, "R9", "held word sent next frame",
          {got, 8'(ur_cnt - u0)}, {8'hE7, 8'h00});
   endtask

   task automatic t_fs_err;
      logic [W-1:0] got; logic early; int t0, e0, r0;
      t0 = txe_cnt; e0 = rxe_cnt;
      load_word(8'h81);
      r0 = rx_cnt;
      run_frame(8'hF0, 4, 0, 1, 1, 0, '0, got, early);
      run_frame(8'h24, W, 1, 1, 1, 0, '0, got, early);
      chk(txe_cnt == t0 + 1 && rxe_cnt == e0 + 1, "R10", "sync error flags",
          {8'(txe_cnt - t0), 8'(rxe_cnt - e0)}, 16'h0101);
      chk(got == 8'h81, "R10", "tx restarted with word", got, 8'h81);
      chk(rx_cnt == r0 + 1 && rx_last == 8'h24, "R10", "rx restarted, cut word dropped",
          rx_last, 8'h24);
   endtask

   task automatic run_all;
      wait_n(4);
      rst_n = 1'b1;
      wait_n(6);
      t_reset();
      t_basic();
      t_polarity();
      t_edge();
      t_six_pin();
      t_four_pin();
      t_underrun();
      t_collide();
      t_fs_err();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            timed_out = 1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         vectors++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule